// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one vector instruction at a time against a bank of vector registers. An accepted instruction is split into per-element steps. The steps start at element 0 and advance by one element each clock. The walk stops at the count held in a programmable vector-length register, so a short final pass of a strip-mined loop touches only its live elements. Two arithmetic forms write registers: an element-wise add of two vectors, and a multiply of a vector by a broadcast scalar. A signed set-if-less-than compare of a vector against a broadcast scalar rewrites the per-element mask. A fourth opcode loads the vector length from the scalar operand.

Arithmetic results are written only where the mask bit is set. Elements whose bit is clear keep their old contents. The issue side is a valid/ready handshake that carries the opcode, three register indices and a 32-bit scalar. A busy level and a one-cycle done pulse report progress. A host element port writes single elements while the sequencer is idle and reads any element at any time, combinationally. The current mask and vector length are visible as outputs. Elements are 32-bit integers.

Top module: `vseq_top`

## Requirements
- R1: After reset, busy and done are low, every element of every register reads zero, the mask is all ones and the vector length equals MVL (64).
- R2: issueReady equals the inverse of busy. An instruction offered while busy is not taken and has no effect on any register, the mask or the vector length.
- R3: An add, multiply or compare keeps busy high for exactly VLR cycles after the accepting edge. done is high for exactly one cycle, in the cycle after the last element step.
- R4: Opcode 0 (vector add) sets vd[i] = va[i] + vb[i] modulo 2^32 for each i below VLR whose mask bit is set. Elements at or above VLR are unchanged.
- R5: Opcode 1 (scalar multiply) sets vd[i] to the low 32 bits of va[i] times the scalar, under the same VLR and mask rules as R4.
- R6: During opcodes 0 and 1, an element whose mask bit is 0 keeps its previous value.
- R7: Opcode 2 (compare) sets mask bit i to 1 when va[i], read as signed, is less than the signed scalar, for every i below VLR, whatever the old mask was. It clears the mask bits at and above VLR and writes no vector register.
- R8: Opcode 3 (set length) loads VLR from the scalar, or loads MVL when the scalar is 0 or above MVL. It holds busy for one cycle and then pulses done.
- R9: A host element write while idle is visible on the read port in the next cycle. A host write offered while busy is ignored. The read port reflects the addressed element combinationally.
- R10: Element steps run in ascending order from element 0, one per cycle. After k clock edges past the accepting edge, elements below k are written and element k is not yet written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | Sequencer can take an instruction |
| issueOp | input | 2 | Opcode: 0 add, 1 scalar multiply, 2 compare, 3 set length |
| issueDst | input | 4 | Destination register index |
| issueSrcA | input | 4 | First source register index |
| issueSrcB | input | 4 | Second source register index (add only) |
| issueScalar | input | 32 | Broadcast scalar or new length |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| hostWrEn | input | 1 | Host element write strobe |
| hostWrReg | input | 4 | Host write register index |
| hostWrElem | input | 6 | Host write element index |
| hostWrData | input | 32 | Host write data |
| hostRdReg | input | 4 | Host read register index |
| hostRdElem | input | 6 | Host read element index |
| hostRdData | output | 32 | Addressed element value |
| maskOut | output | 64 | Current mask, bit i for element i |
| vlrOut | output | 7 | Current vector length |

## Verification
The checks inside the design assume that reset is asserted before the first instruction. They also assume that the handshake inputs change only between clock edges, so the element counter always starts from zero on an accepted issue. The stimulus drives every input on the falling edge. It offers instructions and host writes while busy only on purpose, to show that they are refused. All data comes in through the host port, so each register holds known contents before the programme runs. The programme mixes signed overflow, negative operands, lengths of 1, 8, 10 and 64, and out-of-range length requests, all within the four defined opcodes.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    OP_ADDVV = 2'd0,
    OP_MULVS = 2'd1,
    OP_SLTVS = 2'd2,
    OP_SETVL = 2'd3
  } vecOp_e;

  // strobes from the sequencing control to the element datapath
  typedef struct packed {
    vecOp_e op;
    logic   elemWr;
    logic   maskWr;
    logic   clrUpper;
  } dpStrobe_t;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MVL      = 64,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ELEM_W  = $clog2(MVL),
  localparam int VLR_W   = $clog2(MVL + 1),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  vecOp_e            issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [DATA_W-1:0] issueScalar,
  output logic              issueReady,
  output logic              busy,
  output logic              done,
  output dpStrobe_t         strobe,
  output logic [ELEM_W-1:0] elemIdx,
  output logic [REG_W-1:0]  dstIdx,
  output logic [REG_W-1:0]  srcAIdx,
  output logic [REG_W-1:0]  srcBIdx,
  output logic [DATA_W-1:0] scalar,
  output logic [VLR_W-1:0]  vlr
);

  logic              busyQ;
  logic              doneQ;
  logic [ELEM_W-1:0] elemQ;
  vecOp_e            opQ;
  logic [REG_W-1:0]  dstQ;
  logic [REG_W-1:0]  srcAQ;
  logic [REG_W-1:0]  srcBQ;
  logic [DATA_W-1:0] scalarQ;
  logic [VLR_W-1:0]  vlrQ;
  logic              lastStep;

  function automatic logic [VLR_W-1:0] clampLen(input logic [DATA_W-1:0] s);
    if (s == '0 || s > DATA_W'(MVL)) return VLR_W'(MVL);
    return s[VLR_W-1:0];
  endfunction

  assign lastStep = (opQ == OP_SETVL) || ({1'b0, elemQ} == vlrQ - VLR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      elemQ   <= '0;
      opQ     <= OP_ADDVV;
      dstQ    <= '0;
      srcAQ   <= '0;
      srcBQ   <= '0;
      scalarQ <= '0;
      vlrQ    <= VLR_W'(MVL);
    end else begin
      doneQ <= 1'b0;
      if (!busyQ && issueValid) begin
        busyQ   <= 1'b1;
        elemQ   <= '0;
        opQ     <= issueOp;
        dstQ    <= issueDst;
        srcAQ   <= issueSrcA;
        srcBQ   <= issueSrcB;
        scalarQ <= issueScalar;
      end else if (busyQ) begin
        if (opQ == OP_SETVL) vlrQ <= clampLen(scalarQ);
        if (lastStep) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          elemQ <= elemQ + ELEM_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobe.op       = opQ;
    strobe.elemWr   = busyQ && (opQ == OP_ADDVV || opQ == OP_MULVS);
    strobe.maskWr   = busyQ && (opQ == OP_SLTVS);
    strobe.clrUpper = busyQ && (opQ == OP_SLTVS) && (elemQ == '0);
  end

  assign issueReady = !busyQ;
  assign busy       = busyQ;
  assign done       = doneQ;
  assign elemIdx    = elemQ;
  assign dstIdx     = dstQ;
  assign srcAIdx    = srcAQ;
  assign srcBIdx    = srcBQ;
  assign scalar     = scalarQ;
  assign vlr        = vlrQ;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_done_on_finish_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);

  assert_vlr_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    (vlrQ >= VLR_W'(1)) && (vlrQ <= VLR_W'(MVL)));

  assert_elem_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> (elemQ == $past(elemQ) + ELEM_W'(1)));

  assert_elem_below_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> ({1'b0, elemQ} < vlrQ));

endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int MVL      = 64,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ELEM_W  = $clog2(MVL),
  localparam int VLR_W   = $clog2(MVL + 1),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int DEPTH   = NUM_REGS * MVL,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic [ELEM_W-1:0] elemIdx,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic [REG_W-1:0]  srcAIdx,
  input  logic [REG_W-1:0]  srcBIdx,
  input  logic [DATA_W-1:0] scalar,
  input  logic [VLR_W-1:0]  vlr,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrReg,
  input  logic [ELEM_W-1:0] hostWrElem,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [REG_W-1:0]  hostRdReg,
  input  logic [ELEM_W-1:0] hostRdElem,
  output logic [DATA_W-1:0] hostRdData,
  output logic [MVL-1:0]    maskOut
);

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [MVL-1:0]    maskQ;
  logic [MVL-1:0]    lowMask;
  logic [MVL-1:0]    nextMask;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] result;
  logic              lessThan;

  function automatic logic [ADDR_W-1:0] elemAddr(input logic [REG_W-1:0] r,
                                                 input logic [ELEM_W-1:0] e);
    return ADDR_W'(r) * ADDR_W'(MVL) + ADDR_W'(e);
  endfunction

  // bit g is set when element g lies inside the current length
  for (genvar g = 0; g < MVL; g++) begin : gLowMask
    assign lowMask[g] = (VLR_W'(g) < vlr);
  end

  assign opA        = regFile[elemAddr(srcAIdx, elemIdx)];
  assign opB        = regFile[elemAddr(srcBIdx, elemIdx)];
  assign hostRdData = regFile[elemAddr(hostRdReg, hostRdElem)];
  assign lessThan   = $signed(opA) < $signed(scalar);

  always_comb begin
    case (strobe.op)
      OP_ADDVV: result = opA + opB;
      OP_MULVS: result = DATA_W'(opA * scalar);
      default:  result = opA;
    endcase
  end

  always_comb begin
    nextMask = strobe.clrUpper ? (maskQ & lowMask) : maskQ;
    nextMask[elemIdx] = lessThan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
      maskQ <= '1;
    end else begin
      if (strobe.elemWr) begin
        if (maskQ[elemIdx]) regFile[elemAddr(dstIdx, elemIdx)] <= result;
      end else if (hostWrEn && !busy) begin
        regFile[elemAddr(hostWrReg, hostWrElem)] <= hostWrData;
      end
      if (strobe.maskWr) maskQ <= nextMask;
    end
  end

  assign maskOut = maskQ;

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.maskWr) |-> (maskQ == $past(maskQ)));

endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int MVL      = 64,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ELEM_W  = $clog2(MVL),
  localparam int VLR_W   = $clog2(MVL + 1),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [1:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [DATA_W-1:0] issueScalar,
  output logic              busy,
  output logic              done,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrReg,
  input  logic [ELEM_W-1:0] hostWrElem,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [REG_W-1:0]  hostRdReg,
  input  logic [ELEM_W-1:0] hostRdElem,
  output logic [DATA_W-1:0] hostRdData,
  output logic [MVL-1:0]    maskOut,
  output logic [VLR_W-1:0]  vlrOut
);

  dpStrobe_t         strobe;
  logic [ELEM_W-1:0] elemIdx;
  logic [REG_W-1:0]  dstIdx;
  logic [REG_W-1:0]  srcAIdx;
  logic [REG_W-1:0]  srcBIdx;
  logic [DATA_W-1:0] scalar;
  logic [VLR_W-1:0]  vlr;

  vseq_ctrl #(.MVL(MVL), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (vecOp_e'(issueOp)),
    .issueDst   (issueDst),
    .issueSrcA  (issueSrcA),
    .issueSrcB  (issueSrcB),
    .issueScalar(issueScalar),
    .issueReady (issueReady),
    .busy       (busy),
    .done       (done),
    .strobe     (strobe),
    .elemIdx    (elemIdx),
    .dstIdx     (dstIdx),
    .srcAIdx    (srcAIdx),
    .srcBIdx    (srcBIdx),
    .scalar     (scalar),
    .vlr        (vlr)
  );

  vseq_datapath #(.MVL(MVL), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .elemIdx   (elemIdx),
    .dstIdx    (dstIdx),
    .srcAIdx   (srcAIdx),
    .srcBIdx   (srcBIdx),
    .scalar    (scalar),
    .vlr       (vlr),
    .hostWrEn  (hostWrEn),
    .hostWrReg (hostWrReg),
    .hostWrElem(hostWrElem),
    .hostWrData(hostWrData),
    .hostRdReg (hostRdReg),
    .hostRdElem(hostRdElem),
    .hostRdData(hostRdData),
    .maskOut   (maskOut)
  );

  assign vlrOut = vlr;

endmodule

// File: tb/test_vseq_top.sv
module test_vseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100000;
  localparam int MVL        = 64;
  localparam int NREG       = 16;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  dst;
    logic [3:0]  srcA;
    logic [3:0]  srcB;
    logic [31:0] s;
  } instr_t;

  localparam int NPROG = 14;
  localparam instr_t PROG [NPROG] = '{
    '{2'd0, 4'd3, 4'd1, 4'd2, 32'd0},          // add v3=v1+v2, full length
    '{2'd1, 4'd4, 4'd1, 4'd0, 32'hFFFF_FFFD},  // mul v4=v1*-3
    '{2'd3, 4'd0, 4'd0, 4'd0, 32'd10},         // length 10
    '{2'd2, 4'd0, 4'd2, 4'd0, 32'd0},          // mask = v2<0
    '{2'd0, 4'd3, 4'd3, 4'd1, 32'd0},          // masked add in place
    '{2'd1, 4'd5, 4'd2, 4'd0, 32'd7},          // masked mul
    '{2'd3, 4'd0, 4'd0, 4'd0, 32'd0},          // length 0 -> MVL
    '{2'd0, 4'd6, 4'd6, 4'd1, 32'd0},          // upper mask bits cleared
    '{2'd3, 4'd0, 4'd0, 4'd0, 32'd100},        // length 100 -> MVL
    '{2'd2, 4'd0, 4'd1, 4'd0, 32'd40},         // mask = v1<40
    '{2'd3, 4'd0, 4'd0, 4'd0, 32'd64},         // length exactly MVL
    '{2'd1, 4'd7, 4'd1, 4'd0, 32'h0001_0000},  // masked mul by 2^16
    '{2'd3, 4'd0, 4'd0, 4'd0, 32'd1},          // length 1
    '{2'd0, 4'd8, 4'd1, 4'd1, 32'd0}           // single element add
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueReady;
  logic [1:0]  issueOp = '0;
  logic [3:0]  issueDst = '0;
  logic [3:0]  issueSrcA = '0;
  logic [3:0]  issueSrcB = '0;
  logic [31:0] issueScalar = '0;
  logic        busy;
  logic        done;
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostWrReg = '0;
  logic [5:0]  hostWrElem = '0;
  logic [31:0] hostWrData = '0;
  logic [3:0]  hostRdReg = '0;
  logic [5:0]  hostRdElem = '0;
  logic [31:0] hostRdData;
  logic [63:0] maskOut;
  logic [6:0]  vlrOut;

  logic [31:0] mdl [NREG][MVL];
  logic [63:0] mdlMask;
  int          mdlVlr;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  vseq_top i_vseq_top (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueOp(issueOp), .issueDst(issueDst), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueScalar(issueScalar), .busy(busy), .done(done),
    .hostWrEn(hostWrEn), .hostWrReg(hostWrReg), .hostWrElem(hostWrElem),
    .hostWrData(hostWrData), .hostRdReg(hostRdReg), .hostRdElem(hostRdElem),
    .hostRdData(hostRdData), .maskOut(maskOut), .vlrOut(vlrOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      bad++;
      total++;
      $display("FAIL watchdog: run still going after %0d cycles, expected finish", LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readElem(input int r, input int e, output logic [31:0] v);
    hostRdReg  = 4'(r);
    hostRdElem = 6'(e);
    #1;
    v = hostRdData;
  endtask

  task automatic checkState(input string req);
    logic [31:0] v;
    int errs = 0;
    for (int r = 0; r < NREG; r++) begin
      for (int e = 0; e < MVL; e++) begin
        readElem(r, e, v);
        if (v !== mdl[r][e]) begin
          if (errs == 0)
            $display("FAIL %s: v%0d[%0d] actual=%h expected=%h", req, r, e, v, mdl[r][e]);
          errs++;
        end
      end
    end
    total++;
    if (errs != 0) bad++;
    check(req, maskOut, mdlMask);
    check(req, 64'(vlrOut), 64'(mdlVlr));
    @(negedge clk);
  endtask

  task automatic hostWrite(input int r, input int e, input logic [31:0] d);
    hostWrEn   = 1'b1;
    hostWrReg  = 4'(r);
    hostWrElem = 6'(e);
    hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    mdl[r][e] = d;
  endtask

  task automatic runInstr(input instr_t ins);
    int busyCnt = 0;
    int expBusy;
    string req;
    expBusy = (ins.op == 2'd3) ? 1 : mdlVlr;
    issueValid  = 1'b1;
    issueOp     = ins.op;
    issueDst    = ins.dst;
    issueSrcA   = ins.srcA;
    issueSrcB   = ins.srcB;
    issueScalar = ins.s;
    @(negedge clk);
    issueValid = 1'b0;
    while (!done) begin
      if (busy) busyCnt++;
      @(negedge clk);
    end
    check(ins.op == 2'd3 ? "R8 busy length" : "R3 busy length", 64'(busyCnt), 64'(expBusy));
    @(negedge clk);
    check("R3 done single pulse", 64'(done), 64'd0);
    case (ins.op)
      2'd0: for (int e = 0; e < mdlVlr; e++)
              if (mdlMask[e]) mdl[ins.dst][e] = mdl[ins.srcA][e] + mdl[ins.srcB][e];
      2'd1: for (int e = 0; e < mdlVlr; e++)
              if (mdlMask[e]) mdl[ins.dst][e] = mdl[ins.srcA][e] * ins.s;
      2'd2: for (int e = 0; e < MVL; e++)
              mdlMask[e] = (e < mdlVlr) && ($signed(mdl[ins.srcA][e]) < $signed(ins.s));
      default: mdlVlr = (ins.s == 0 || ins.s > MVL) ? MVL : int'(ins.s);
    endcase
    case (ins.op)
      2'd0:    req = "R4/R6 add";
      2'd1:    req = "R5/R6 mul";
      2'd2:    req = "R7 compare";
      default: req = "R8 length";
    endcase
    checkState(req);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] exp0;
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < MVL; e++) mdl[r][e] = '0;
    mdlMask = '1;
    mdlVlr  = MVL;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 done after reset", 64'(done), 64'd0);
    check("R2 ready when idle", 64'(issueReady), 64'd1);
    checkState("R1 reset contents");

    // load operands through the host port (R9)
    for (int e = 0; e < MVL; e++) begin
      hostWrite(1, e, 32'(3 * e + 1));
      hostWrite(2, e, e[0] ? -32'(7 * e) : 32'h7FFF_FFF0 + 32'(e));
      hostWrite(6, e, 32'(100 + e));
    end
    checkState("R9 host load");

    // programme table
    for (int i = 0; i < NPROG; i++) runInstr(PROG[i]);

    // directed: refusal while busy and element ordering
    runInstr('{2'd3, 4'd0, 4'd0, 4'd0, 32'd8});
    issueValid  = 1'b1;
    issueOp     = 2'd0;
    issueDst    = 4'd9;
    issueSrcA   = 4'd1;
    issueSrcB   = 4'd2;
    issueScalar = '0;
    @(negedge clk);
    check("R2 ready drops while busy", 64'(issueReady), 64'd0);
    issueOp    = 2'd1;
    issueDst   = 4'd10;
    issueScalar = 32'd5;
    hostWrEn   = 1'b1;
    hostWrReg  = 4'd11;
    hostWrElem = 6'd0;
    hostWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    exp0 = mdl[1][0] + mdl[2][0];
    readElem(9, 0, v);
    check("R10 element 0 written first", 64'(v), 64'(exp0));
    readElem(9, 1, v);
    check("R10 element 1 not yet written", 64'(v), 64'd0);
    @(negedge clk);
    issueValid = 1'b0;
    hostWrEn   = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    for (int e = 0; e < 8; e++)
      if (mdlMask[e]) mdl[9][e] = mdl[1][e] + mdl[2][e];
    readElem(11, 0, v);
    check("R9 host write ignored while busy", 64'(v), 64'd0);
    readElem(10, 3, v);
    check("R2 refused instruction has no effect", 64'(v), 64'd0);
    checkState("R2/R4 state after refused issue");

    // R9 idle host write visible next cycle
    hostWrite(11, 5, 32'h1234_5678);
    readElem(11, 5, v);
    check("R9 idle host write", 64'(v), 64'h1234_5678);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule